// File: doc/BRIEF.md
# Three-State Serial Result Port

This block is the device-side digital face of a serial sampling converter, written so that it can be synthesized and used as a bus-functional responder. A host drives two asynchronous inputs: a conversion strobe and a shift clock. The block answers on a serial data line, which has its own output-enable. A stub converter supplies a signed sample. The block clamps that sample into an unsigned straight-binary code, and that code is what the host reads.

A rising strobe starts a conversion. The conversion lasts a fixed number of ticks of the fast internal clock. When the count expires, the clamped code is captured. The output enable is withdrawn at once, combinationally, whenever the strobe is high. When the strobe falls, the port enables its output and presents the most significant bit of the last completed code. Each falling edge of the shift clock then moves the line to the next lower bit. After the least significant bit, the line reads zero for as long as shift edges keep arriving.

If the strobe drops before the conversion count expires, the conversion is abandoned. The port then presents the previous completed code. Both host inputs pass through two-flop synchronizers, and their edges are detected on the internal clock.

Top module: `sar_serial_port`

## Requirements
- R1: While `conv_in` is high, `sdo_oe` is 0. This holds combinationally, in the same instant that `conv_in` rises.
- R2: Within 3 rising edges of `clk` after `conv_in` falls, `sdo_oe` is 1 and `sdo` shows bit DATA_W-1 (the MSB) of the last completed code.
- R3: Within 3 rising edges of `clk` after each falling edge of `sck_in` during a read, `sdo` steps to the next lower bit. After the k-th such edge, `sdo` shows bit DATA_W-1-k.
- R4: Once bit 0 has been shown, every further falling edge of `sck_in` leaves `sdo` at 0, without limit.
- R5: A conversion completes CONV_TICKS `clk` cycles after its rising strobe is detected. The clamped value of `sample_in` at that moment becomes the code for every following read.
- R6: If `conv_in` falls before the conversion completes, that conversion is discarded. The read returns the previous completed code unchanged.
- R7: The code is straight binary. A negative `sample_in` gives all zeros. A value above 2^DATA_W-1 gives all ones. Any other value is passed through unchanged.
- R8: After reset, `sdo_oe` is 0, `sdo` is 0, and the stored code is zero until a conversion completes.
- R9: Falling edges of `sck_in` while `conv_in` is high have no effect on the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast internal clock; it times conversions and samples both host inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_in | input | 1 | Asynchronous conversion strobe from the host |
| sck_in | input | 1 | Asynchronous shift clock from the host |
| sample_in | input | SAMPLE_W | Signed sample from the stub converter |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable for `sdo`; when it is 0, the line is treated as high impedance |

## Verification
The checker watches several properties on every cycle. The enable is off whenever the strobe is high. Each load presents the MSB of the stored code. Each shift presents the bit that was next in line. After the full word has been sent, the line stays at zero. The stored code never changes except on a completion event.

Other behaviours only the bench scenarios can show. These are the exact conversion length, the discard of an aborted conversion, the clamping at both ends of the range, and the indifference to shift edges during a conversion. The bench shows them by reassembling whole words at the ports and comparing each against a code computed independently.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_t;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic now_o,
  output logic was_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], async_in};
  end

  assign now_o = pipe_q[STAGES-1];
  assign was_o = pipe_q[STAGES];
endmodule

// File: rtl/sps_conv_timer.sv
module sps_conv_timer
  import sps_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int SAMPLE_W   = 14,
  parameter int CONV_TICKS = 280
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       abort_i,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  output logic [DATA_W-1:0]          result_q,
  output logic                       done_o
);
  localparam int CNT_W = $clog2(CONV_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_TICKS - 1);
  localparam logic signed [SAMPLE_W:0] FULL_CODE = $signed((SAMPLE_W+1)'((1 << DATA_W) - 1));

  // Straight-binary clamp of a signed sample into DATA_W bits.
  function automatic logic [DATA_W-1:0] clamp_code(input logic signed [SAMPLE_W-1:0] raw);
    if (raw[SAMPLE_W-1])      return '0;
    else if (raw > FULL_CODE) return '1;
    else                      return raw[DATA_W-1:0];
  endfunction

  tmr_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (state_q == TMR_RUN) && !start_i && !abort_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TMR_IDLE;
      cnt_q    <= '0;
      result_q <= '0;
    end else if (start_i) begin
      state_q <= TMR_RUN;
      cnt_q   <= '0;
    end else if (state_q == TMR_RUN) begin
      if (abort_i || done_o) state_q <= TMR_IDLE;
      else                   cnt_q   <= cnt_q + 1'b1;
      if (done_o)            result_q <= clamp_code(sample_in);
    end
  end
endmodule

// File: rtl/sps_shift_out.sv
module sps_shift_out #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              advance_i,
  input  logic              quiet_i,
  input  logic [DATA_W-1:0] load_word,
  output logic              bit_o,
  output logic              next_bit_o,
  output logic              drive_o
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      drive_o <= 1'b0;
    end else if (load_i) begin
      word_q  <= load_word;
      drive_o <= 1'b1;
    end else begin
      if (quiet_i)             drive_o <= 1'b0;
      if (advance_i && drive_o) word_q <= {word_q[DATA_W-2:0], 1'b0};
    end
  end

  assign bit_o      = word_q[DATA_W-1];
  assign next_bit_o = word_q[DATA_W-2];
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int DATA_W      = 12,
  parameter int SAMPLE_W    = 14,
  parameter int CONV_TICKS  = 280,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       conv_in,
  input  logic                       sck_in,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  output logic                       sdo,
  output logic                       sdo_oe
);
  logic conv_now, conv_was, sck_now, sck_was;
  logic conv_rise_evt, conv_fall_evt, sck_fall_evt, conv_done_evt;
  logic drive_q, next_bit;
  logic [DATA_W-1:0] result_q;

  sps_sync #(.STAGES(SYNC_STAGES)) u_conv_sync (
    .clk(clk), .rst_n(rst_n), .async_in(conv_in), .now_o(conv_now), .was_o(conv_was));
  sps_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sck_in), .now_o(sck_now), .was_o(sck_was));

  // Named events for the checker
  assign conv_rise_evt = conv_now & ~conv_was;
  assign conv_fall_evt = ~conv_now & conv_was;
  assign sck_fall_evt  = ~sck_now & sck_was;

  sps_conv_timer #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W), .CONV_TICKS(CONV_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(conv_rise_evt), .abort_i(conv_fall_evt),
    .sample_in(sample_in), .result_q(result_q), .done_o(conv_done_evt));

  sps_shift_out #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(conv_fall_evt), .advance_i(sck_fall_evt),
    .quiet_i(conv_rise_evt), .load_word(result_q), .bit_o(sdo),
    .next_bit_o(next_bit), .drive_o(drive_q));

  // Raw strobe gates the enable so high impedance follows it without a clock
  assign sdo_oe = drive_q & ~conv_in;
endmodule

// File: rtl/sps_port_checker.sv
module sps_port_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_in,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              conv_fall_evt,
  input logic              sck_fall_evt,
  input logic              conv_done_evt,
  input logic              drive_q,
  input logic              next_bit,
  input logic [DATA_W-1:0] result_q
);
  localparam int CW = $clog2(DATA_W + 1);
  logic [CW-1:0] sent_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                                    sent_cnt <= '0;
    else if (conv_fall_evt)                                        sent_cnt <= '0;
    else if (sck_fall_evt && drive_q && sent_cnt != CW'(DATA_W))   sent_cnt <= sent_cnt + 1'b1;
  end

  // R1
  tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_in |-> !sdo_oe);
  // R2
  msb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fall_evt |=> (sdo == $past(result_q[DATA_W-1])));
  // R3
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall_evt && drive_q && !conv_fall_evt) |=> (sdo == $past(next_bit)));
  // R4
  zero_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q && sent_cnt == CW'(DATA_W)) |-> (sdo == 1'b0));
  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done_evt |=> $stable(result_q));
endmodule

bind sar_serial_port sps_port_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_in(conv_in), .sdo(sdo), .sdo_oe(sdo_oe),
  .conv_fall_evt(conv_fall_evt), .sck_fall_evt(sck_fall_evt),
  .conv_done_evt(conv_done_evt), .drive_q(drive_q), .next_bit(next_bit),
  .result_q(result_q));

// File: tb/sar_serial_port_bench.sv
module sar_serial_port_bench;
  localparam int DW = 12, SW = 14, TICKS = 280;

  logic clk = 1'b0, rst_n = 1'b0, conv = 1'b0, sck = 1'b0;
  logic signed [SW-1:0] sample = '0;
  logic sdo, sdo_oe;
  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] last_code = '0;

  always #2.5 clk = ~clk;

  sar_serial_port #(.DATA_W(DW), .SAMPLE_W(SW), .CONV_TICKS(TICKS)) u_sar_serial_port (
    .clk(clk), .rst_n(rst_n), .conv_in(conv), .sck_in(sck), .sample_in(sample),
    .sdo(sdo), .sdo_oe(sdo_oe));

  function automatic logic [DW-1:0] expect_code(input int s);
    if (s < 0)              return '0;
    if (s > (1 << DW) - 1)  return {DW{1'b1}};
    return DW'(s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sck();
    @(negedge clk) sck = 1'b1;
    wait_n(3);
    sck = 1'b0;
    wait_n(4);
  endtask

  // One strobe/read cycle; tag names the requirement the whole word is checked for
  task automatic frame(input string tag, input int s, input bit full,
                       input bit sck_during, input int extra);
    logic [DW-1:0] exp, rx;
    @(negedge clk);
    sample = SW'(s);
    conv   = 1'b1;
    #1 check("R1 enable off at strobe rise", 32'(sdo_oe), 0);
    wait_n(4);
    if (sck_during) begin
      for (int k = 0; k < 3; k++) pulse_sck();   // R9 stimulus
    end
    wait_n(full ? TICKS + 10 : 4);
    check("R1 enable off during conversion", 32'(sdo_oe), 0);
    if (full) last_code = expect_code(s);
    exp = last_code;
    @(negedge clk) conv = 1'b0;
    wait_n(4);
    check("R2 enable", 32'(sdo_oe), 1);
    check("R2 msb", 32'(sdo), 32'(exp[DW-1]));
    rx = '0;
    rx[DW-1] = sdo;
    for (int i = 1; i < DW + extra; i++) begin
      pulse_sck();
      if (i < DW) begin
        check("R3 bit", 32'(sdo), 32'(exp[DW-1-i]));
        rx[DW-1-i] = sdo;
      end else begin
        check("R4 tail zero", 32'(sdo), 0);
      end
    end
    check(tag, 32'(rx), 32'(exp));
  endtask

  initial begin
    void'($urandom(32'd1234));
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);
    check("R8 reset enable", 32'(sdo_oe), 0);
    check("R8 reset data", 32'(sdo), 0);
    frame("R8 code zero before any conversion", 1234, 1'b0, 1'b0, 0);
    frame("R5 full conversion", 12'hA5C, 1'b1, 1'b0, 0);
    frame("R6 aborted keeps previous", 12'h3C3, 1'b0, 1'b0, 0);
    frame("R7 negative clamps to zero", -1, 1'b1, 1'b0, 0);
    frame("R7 above range clamps to ones", 8191, 1'b1, 1'b0, 2);
    frame("R7 top code passes", 4095, 1'b1, 1'b0, 0);
    frame("R7 just above range", 4096, 1'b1, 1'b0, 0);
    frame("R7 zero passes", 0, 1'b1, 1'b0, 0);
    frame("R9 shift edges during conversion", 12'h6B1, 1'b1, 1'b1, 0);
    frame("R4 long zero tail", 12'hFFF, 1'b1, 1'b0, 6);
    for (int f = 0; f < 30; f++) begin
      logic [SW-1:0] rr;
      rr = SW'($urandom);
      frame("R5 random frame", int'($signed(rr)), ($urandom % 5) != 0,
            ($urandom % 4) == 0, int'($urandom % 4));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule